// File: doc/BRIEF.md
# Five-bit Maximal-Length Pseudo-Random Bit Source

The block is a five-stage shift register with linear feedback. It produces a pseudo-random bit stream with a period of 31. On each enabled clock the stored word moves one position toward bit 0. A new bit, formed as the exclusive-OR of bit 2 and bit 0, enters at bit 4. The block presents this new bit on a serial output in the same cycle, before the edge that shifts it in, and it also presents the whole five-bit state in parallel.

A synchronous reset places the register at a known nonzero starting word. A load strobe with a five-bit seed can restart the sequence from any point. The all-zero word would lock the register, so the block substitutes the word 00001 when a seed of zero is loaded. When the enable is low and no load or reset is present, the register keeps its value.

Top module: `lfsr5_stream`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 00001 (bit 4 down to bit 0). Reset takes priority over load and enable.
- R2: When `stepEn` is high and `seedLoad` is low, each edge moves bits 4..1 into bits 3..0 and writes bit2 XOR bit0 of the old state into bit 4. Starting from 00001, the first twelve states are 10000, 01000, 00100, 10010, 01001, 10100, 11010, 01101, 00110, 10011, 11001 and 11100.
- R3: `serialBit` always equals bit2 XOR bit0 of the present `stateOut`. It is valid in the cycle before that bit is shifted in.
- R4: When `rst`, `seedLoad` and `stepEn` are all low, the state does not change.
- R5: When `seedLoad` is high and `rst` is low, the next state is `seedValue`, whatever `stepEn` is.
- R6: Loading a `seedValue` of 00000 gives the state 00001.
- R7: After reset the state is never 00000.
- R8: Stepping continuously from 00001 visits 31 distinct states and returns to 00001 on exactly the 31st step. The 31 serial bits of one period form a rotation of 1111100011011101010000100101100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Load `seedValue` on the next edge |
| seedValue | input | 5 | Seed word, bit 4 is the feedback entry stage |
| stepEn | input | 1 | Advance the sequence one step per edge |
| serialBit | output | 1 | Feedback bit of the current state |
| stateOut | output | 5 | Present register contents |

## Verification
The bench targets the following corner cases:
- **Shift direction and taps.** The first twelve states are compared against a fixed list. A reversed shift or a wrong tap pair would leave that list after only a step or two.
- **Period.** One full period is walked to confirm the length is exactly 31. A design that could fall into the zero word would stall there forever and never return to the start.
- **Zero seed.** A seed of zero is loaded to show that it is replaced by 00001. A design that loaded it unchanged would freeze with a constant zero output.
- **Priority.** Load with enable high, and reset with load high, check the priority order. A design with the wrong order would step instead of load, or load instead of reset.
- **Random stress.** A long random run compares every cycle against a bench model.

// File: rtl/lfsr5_pkg.sv
package lfsr5_pkg;
  localparam int LFSR_W = 5;
  localparam int TAP_HI = 2;
  localparam int TAP_LO = 0;
  localparam logic [LFSR_W-1:0] TAP_MASK   = LFSR_W'((1 << TAP_HI) | (1 << TAP_LO));
  localparam logic [LFSR_W-1:0] RESET_SEED = LFSR_W'(1);

  typedef struct packed {
    logic doLoad;
    logic doStep;
  } lfsrCtrl_t;
endpackage

// File: rtl/lfsr5_ctrl.sv
module lfsr5_ctrl
  import lfsr5_pkg::*;
(
  input  logic              seedLoad,
  input  logic [LFSR_W-1:0] seedValue,
  input  logic              stepEn,
  output lfsrCtrl_t         ctrl,
  output logic [LFSR_W-1:0] loadWord
);
  // Load wins over step; reset is handled in the datapath register itself.
  always_comb begin
    ctrl.doLoad = seedLoad;
    ctrl.doStep = stepEn & ~seedLoad;
  end

  // A zero seed would lock the register, so it is swapped for the reset word.
  always_comb begin
    if (seedValue == '0) loadWord = RESET_SEED;
    else                 loadWord = seedValue;
  end
endmodule

// File: rtl/lfsr5_datapath.sv
module lfsr5_datapath
  import lfsr5_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  lfsrCtrl_t         ctrl,
  input  logic [LFSR_W-1:0] loadWord,
  output logic [LFSR_W-1:0] stateQ,
  output logic              fbBit
);
  logic [LFSR_W-1:0] stateD;

  assign fbBit = ^(stateQ & TAP_MASK);

  always_comb begin
    stateD = stateQ;
    if (ctrl.doLoad)      stateD = loadWord;
    else if (ctrl.doStep) stateD = {fbBit, stateQ[LFSR_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= RESET_SEED;
    else     stateQ <= stateD;
  end

  // R1
  reset_seed_chk: assert property (@(posedge clk) rst |=> stateQ == RESET_SEED);

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.doStep && !ctrl.doLoad) |=>
      (stateQ[LFSR_W-2:0] == $past(stateQ[LFSR_W-1:1])) &&
      (stateQ[LFSR_W-1] == ($past(stateQ[TAP_HI]) ^ $past(stateQ[TAP_LO]))));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.doStep && !ctrl.doLoad) |=> $stable(stateQ));

  // R5
  seed_take_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.doLoad |=> stateQ == $past(loadWord));

  // R7
  no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0);
endmodule

// File: rtl/lfsr5_stream.sv
module lfsr5_stream
  import lfsr5_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              seedLoad,
  input  logic [LFSR_W-1:0] seedValue,
  input  logic              stepEn,
  output logic              serialBit,
  output logic [LFSR_W-1:0] stateOut
);
  lfsrCtrl_t         ctrlBus;
  logic [LFSR_W-1:0] loadWord;

  lfsr5_ctrl u_ctrl (
    .seedLoad (seedLoad),
    .seedValue(seedValue),
    .stepEn   (stepEn),
    .ctrl     (ctrlBus),
    .loadWord (loadWord)
  );

  lfsr5_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrlBus),
    .loadWord(loadWord),
    .stateQ  (stateOut),
    .fbBit   (serialBit)
  );
endmodule

// File: tb/lfsr5_stream_bench.sv
module lfsr5_stream_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seedLoad = 1'b0;
  logic [4:0] seedValue = 5'd0;
  logic       stepEn = 1'b0;
  logic       serialBit;
  logic [4:0] stateOut;

  int total = 0;
  int bad = 0;
  logic [4:0] model = 5'b00001;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  lfsr5_stream u_lfsr5_stream (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedValue(seedValue),
    .stepEn(stepEn), .serialBit(serialBit), .stateOut(stateOut)
  );

  function automatic logic [4:0] stepOf(input logic [4:0] s);
    return {s[2] ^ s[0], s[4:1]};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic l, input logic [4:0] s, input logic e);
    @(negedge clk);
    rst = r; seedLoad = l; seedValue = s; stepEn = e;
    @(posedge clk);
    if (r)      model = 5'b00001;
    else if (l) model = (s == 5'd0) ? 5'b00001 : s;
    else if (e) model = stepOf(model);
    #1;
  endtask

  task automatic checkBoth(input string req);
    check(req, stateOut, model);
    check("R3", {4'd0, serialBit}, {4'd0, model[2] ^ model[0]});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0]  dirList [12];
    logic [31:0] seen;
    logic [30:0] streamV;
    logic [30:0] refStream;
    logic        rotHit;
    logic        earlyReturn;
    logic [4:0]  rs;
    logic [31:0] rnd;

    dirList = '{5'b10000, 5'b01000, 5'b00100, 5'b10010, 5'b01001, 5'b10100,
                5'b11010, 5'b01101, 5'b00110, 5'b10011, 5'b11001, 5'b11100};
    refStream = 31'b1111100011011101010000100101100;
    rnd = $urandom(32'h5EED_0042);

    // R1: reset state
    cycle(1, 0, 0, 0);
    cycle(1, 0, 0, 0);
    checkBoth("R1");

    // R2: directed first twelve states
    cycle(0, 0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      cycle(0, 0, 0, 1);
      check("R2", stateOut, dirList[i]);
      check("R3", {4'd0, serialBit}, {4'd0, stateOut[2] ^ stateOut[0]});
    end

    // R8 / R7: one full period from 00001
    cycle(1, 0, 0, 0);
    seen = '0;
    streamV = '0;
    earlyReturn = 1'b0;
    for (int i = 0; i < 31; i++) begin
      streamV = {streamV[29:0], serialBit};
      cycle(0, 0, 0, 1);
      if (stateOut == 5'd0) check("R7", stateOut, 5'b00001);
      if (seen[stateOut] && i != 30) check("R8", stateOut, 5'b11111);
      seen[stateOut] = 1'b1;
      if (i < 30 && stateOut == 5'b00001) earlyReturn = 1'b1;
    end
    check("R8", stateOut, 5'b00001);
    check("R8", {4'd0, earlyReturn}, 5'd0);
    check("R8", 5'($countones(seen)), 5'd31);
    rotHit = 1'b0;
    for (int k = 0; k < 31; k++) begin
      logic [61:0] dbl;
      dbl = {refStream, refStream} << k;
      if (dbl[61:31] == streamV) rotHit = 1'b1;
    end
    check("R8", {4'd0, rotHit}, 5'd1);

    // R4: hold with enable low
    cycle(0, 0, 0, 1);
    cycle(0, 0, 0, 1);
    rs = stateOut;
    for (int i = 0; i < 4; i++) begin
      cycle(0, 0, 5'b10101, 0);
      check("R4", stateOut, rs);
    end

    // R5: load beats step
    cycle(0, 1, 5'b10110, 1);
    check("R5", stateOut, 5'b10110);
    cycle(0, 1, 5'b01011, 0);
    check("R5", stateOut, 5'b01011);

    // R6: zero seed replaced
    cycle(0, 1, 5'b00000, 1);
    check("R6", stateOut, 5'b00001);
    cycle(0, 0, 0, 1);
    checkBoth("R6");

    // R1: reset beats load and step
    cycle(0, 1, 5'b11111, 0);
    cycle(1, 1, 5'b11000, 1);
    check("R1", stateOut, 5'b00001);

    // Random mix against model
    for (int i = 0; i < 600; i++) begin
      logic r, l, e;
      logic [4:0] s;
      rnd = $urandom;
      r = (rnd[3:0] == 4'd0);
      l = (rnd[7:4] < 4'd3);
      e = rnd[8] | rnd[9];
      s = (rnd[12:10] == 3'd0) ? 5'd0 : rnd[20:16];
      cycle(r, l, s, e);
      checkBoth("R2");
      if (stateOut == 5'd0) check("R7", stateOut, 5'b00001);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule